// File: doc/BRIEF.md
# Dual-Width Packet-Filter Arithmetic Unit

This block is the arithmetic execution stage of a 64-bit packet-filter virtual machine. Each cycle it may accept one instruction: the 8-bit opcode, the current destination register value, the source register value and the 32-bit immediate. One clock later it returns the value to write back to the destination, together with a flag that marks the opcode as one this unit refuses. Register-file access and instruction fetch stay outside. The surrounding pipeline writes `result` back when `out_valid` is high and `illegal` is low, and raises a trap when `illegal` is high.

The same opcode space serves two operand widths. The low three opcode bits pick narrow (32-bit) or wide (64-bit) arithmetic. Bit 3 picks the register or the immediate as the second operand. The top nibble names the operation. Narrow results are always zero-extended into the 64-bit destination. Division and remainder are single-cycle combinational logic, so the unit has a fixed latency of one cycle for every operation.

Top module: `pfalu_top`

## Requirements
- R1: Opcode bits [2:0] equal to 3'b100 select narrow 32-bit operation and 3'b111 select wide 64-bit operation. Any other value raises `illegal` and returns `dst_val` unchanged.
- R2: When opcode bit 3 is 1 the second operand is `src_val`; when it is 0 it is `imm`, sign-extended to 64 bits in wide mode. For END, bit 3 sets the direction instead (see R11).
- R3: In narrow mode both operands are cut to their low 32 bits, and bits [63:32] of every legal non-END result are zero.
- R4: ADD (0x0), SUB (0x1) and MUL (0x2) in the top nibble give the low 32 or 64 bits of the exact result, wrapping modulo the operand width.
- R5: OR (0x4), AND (0x5), XOR (0xa) and MOV (0xb) compute the bitwise function of destination and operand; MOV returns the operand.
- R6: LSH (0x6) and logical RSH (0x7) shift by the operand's low 5 bits in narrow mode and its low 6 bits in wide mode.
- R7: ARSH (0xc) shifts right arithmetically with the same shift-amount masking, filling from bit 31 in narrow mode and bit 63 in wide mode.
- R8: DIV (0x3) is an unsigned quotient; a zero divisor gives 0.
- R9: MOD (0x9) is an unsigned remainder; a zero divisor returns the destination (its low 32 bits zero-extended in narrow mode).
- R10: NEG (0x8) returns the two's-complement negation of the destination at the selected width and ignores `src_val` and `imm`.
- R11: END (0xd) takes its width from `imm` (16, 32 or 64). With bit 3 = 0 it keeps the low width bits and zeroes the rest. With bit 3 = 1 it reverses the byte order of the low width bits and zeroes the rest. Any other `imm` raises `illegal` and returns `dst_val`.
- R12: Top-nibble codes 0xe and 0xf raise `illegal` and return `dst_val` unchanged.
- R13: `out_valid`, `result` and `illegal` show the instruction accepted on the previous rising edge. `out_valid` is high only in the cycle after `in_valid`. Synchronous reset clears all three outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Operation nibble, operand-select bit, class field |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate field |
| out_valid | output | 1 | Result of the previous cycle's instruction is present |
| result | output | 64 | New destination value |
| illegal | output | 1 | Opcode refused; result equals the old destination |

## Verification
The bench goes after the places where a near-miss design gives believable wrong numbers. A narrow operation on a destination whose upper half is non-zero shows up a unit that forgets to truncate or to zero-extend. Shifts by 33 or 65 show up an unmasked shift amount, which would return zero. A negative immediate shows up a missing sign extension in wide mode, and a leaked sign in narrow mode. Zero divisors check that DIV gives 0 and MOD keeps the destination, instead of X or all ones. Byte-order vectors at every width, including the 64-bit little-endian pass-through and an unsupported width, catch swapped directions and swaps over the wrong span. Reserved nibbles and foreign class codes must raise the flag and hand back the destination untouched.

// File: rtl/pfalu_pkg.sv
package pfalu_pkg;

    localparam int XLEN   = 64;
    localparam int HLEN   = 32;
    localparam int IMMW   = 32;
    localparam int OPCW   = 8;
    localparam int SHW_W  = $clog2(XLEN);
    localparam int SHW_N  = $clog2(HLEN);
    localparam int BYTES  = XLEN / 8;
    localparam int NBW    = $clog2(BYTES) + 1;

    localparam logic [2:0] CLS_NARROW = 3'b100;
    localparam logic [2:0] CLS_WIDE   = 3'b111;

    typedef enum logic [3:0] {
        OP_ADD   = 4'h0,
        OP_SUB   = 4'h1,
        OP_MUL   = 4'h2,
        OP_DIV   = 4'h3,
        OP_OR    = 4'h4,
        OP_AND   = 4'h5,
        OP_LSH   = 4'h6,
        OP_RSH   = 4'h7,
        OP_NEG   = 4'h8,
        OP_MOD   = 4'h9,
        OP_XOR   = 4'ha,
        OP_MOV   = 4'hb,
        OP_ARSH  = 4'hc,
        OP_END   = 4'hd,
        OP_RSV_E = 4'he,
        OP_RSV_F = 4'hf
    } alu_op_e;

    typedef struct packed {
        logic    wide;
        logic    use_reg;
        alu_op_e op;
        logic    bad_cls;
        logic    bad_op;
    } dec_t;

    typedef struct packed {
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
    } opnd_t;

    // Reverse the order of the low nb bytes of v; higher bytes become zero.
    function automatic logic [XLEN-1:0] byte_swap(input logic [XLEN-1:0] v,
                                                  input logic [NBW-1:0]  nb);
        logic [XLEN-1:0] r;
        r = '0;
        for (int i = 0; i < BYTES; i++) begin
            if (i < int'(nb)) begin
                r[8*i +: 8] = v[8*(int'(nb) - 1 - i) +: 8];
            end
        end
        return r;
    endfunction

    // Mask that keeps the low nb bytes.
    function automatic logic [XLEN-1:0] low_mask(input logic [NBW-1:0] nb);
        logic [XLEN-1:0] r;
        r = '0;
        for (int i = 0; i < BYTES; i++) begin
            if (i < int'(nb)) begin
                r[8*i +: 8] = 8'hff;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pfalu_decode.sv
module pfalu_decode
    import pfalu_pkg::*;
(
    input  logic [OPCW-1:0] opcode,
    output dec_t            dec
);

    logic [2:0] cls;
    alu_op_e    op;

    always_comb begin
        cls          = opcode[2:0];
        op           = alu_op_e'(opcode[7:4]);
        dec.wide     = (cls == CLS_WIDE);
        dec.use_reg  = opcode[3];
        dec.op       = op;
        dec.bad_cls  = (cls != CLS_NARROW) && (cls != CLS_WIDE);
        dec.bad_op   = (op == OP_RSV_E) || (op == OP_RSV_F);
    end

endmodule

// File: rtl/pfalu_operand.sv
module pfalu_operand
    import pfalu_pkg::*;
(
    input  logic            use_reg,
    input  logic [XLEN-1:0] dst_val,
    input  logic [XLEN-1:0] src_val,
    input  logic [IMMW-1:0] imm,
    output opnd_t           opnd
);

    logic [XLEN-1:0] imm_sx;

    always_comb begin
        imm_sx = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
        opnd.a = dst_val;
        opnd.b = use_reg ? src_val : imm_sx;
    end

endmodule

// File: rtl/pfalu_core.sv
module pfalu_core
    import pfalu_pkg::*;
(
    input  dec_t            dec,
    input  opnd_t           opnd,
    input  logic [IMMW-1:0] imm,
    output logic [XLEN-1:0] res,
    output logic            bad
);

    logic [XLEN-1:0] a_w, b_w, r_w, r_end;
    logic [HLEN-1:0] a_n, b_n, r_n;
    logic [SHW_W-1:0] sh_w;
    logic [SHW_N-1:0] sh_n;
    logic [NBW-1:0]   end_bytes;
    logic             end_ok;

    always_comb begin
        a_w  = opnd.a;
        b_w  = opnd.b;
        a_n  = opnd.a[HLEN-1:0];
        b_n  = opnd.b[HLEN-1:0];
        sh_w = opnd.b[SHW_W-1:0];
        sh_n = opnd.b[SHW_N-1:0];
    end

    // Wide datapath
    always_comb begin
        unique case (dec.op)
            OP_ADD:  r_w = a_w + b_w;
            OP_SUB:  r_w = a_w - b_w;
            OP_MUL:  r_w = a_w * b_w;
            OP_DIV:  r_w = (b_w == '0) ? '0 : a_w / b_w;
            OP_MOD:  r_w = (b_w == '0) ? a_w : a_w % b_w;
            OP_OR:   r_w = a_w | b_w;
            OP_AND:  r_w = a_w & b_w;
            OP_XOR:  r_w = a_w ^ b_w;
            OP_MOV:  r_w = b_w;
            OP_LSH:  r_w = a_w << sh_w;
            OP_RSH:  r_w = a_w >> sh_w;
            OP_ARSH: r_w = $unsigned($signed(a_w) >>> sh_w);
            OP_NEG:  r_w = '0 - a_w;
            default: r_w = a_w;
        endcase
    end

    // Narrow datapath
    always_comb begin
        unique case (dec.op)
            OP_ADD:  r_n = a_n + b_n;
            OP_SUB:  r_n = a_n - b_n;
            OP_MUL:  r_n = a_n * b_n;
            OP_DIV:  r_n = (b_n == '0) ? '0 : a_n / b_n;
            OP_MOD:  r_n = (b_n == '0) ? a_n : a_n % b_n;
            OP_OR:   r_n = a_n | b_n;
            OP_AND:  r_n = a_n & b_n;
            OP_XOR:  r_n = a_n ^ b_n;
            OP_MOV:  r_n = b_n;
            OP_LSH:  r_n = a_n << sh_n;
            OP_RSH:  r_n = a_n >> sh_n;
            OP_ARSH: r_n = $unsigned($signed(a_n) >>> sh_n);
            OP_NEG:  r_n = '0 - a_n;
            default: r_n = a_n;
        endcase
    end

    // Byte-order conversion: width from the immediate, direction from bit 3
    always_comb begin
        end_ok = 1'b1;
        unique case (imm)
            32'd16:  end_bytes = NBW'(2);
            32'd32:  end_bytes = NBW'(4);
            32'd64:  end_bytes = NBW'(BYTES);
            default: begin
                end_bytes = NBW'(BYTES);
                end_ok    = 1'b0;
            end
        endcase
        r_end = dec.use_reg ? byte_swap(a_w, end_bytes)
                            : (a_w & low_mask(end_bytes));
    end

    always_comb begin
        bad = dec.bad_cls | dec.bad_op | ((dec.op == OP_END) & ~end_ok);
        if (bad) begin
            res = a_w;
        end else if (dec.op == OP_END) begin
            res = r_end;
        end else if (dec.wide) begin
            res = r_w;
        end else begin
            res = {{(XLEN-HLEN){1'b0}}, r_n};
        end
    end

endmodule

// File: rtl/pfalu_top.sv
module pfalu_top
    import pfalu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [7:0]      opcode,
    input  logic [63:0]     dst_val,
    input  logic [63:0]     src_val,
    input  logic [31:0]     imm,
    output logic            out_valid,
    output logic [63:0]     result,
    output logic            illegal
);

    dec_t            dec;
    opnd_t           opnd;
    logic [XLEN-1:0] nxt_res;
    logic            nxt_bad;

    pfalu_decode u_decode (
        .opcode (opcode),
        .dec    (dec)
    );

    pfalu_operand u_operand (
        .use_reg (dec.use_reg),
        .dst_val (dst_val),
        .src_val (src_val),
        .imm     (imm),
        .opnd    (opnd)
    );

    pfalu_core u_core (
        .dec  (dec),
        .opnd (opnd),
        .imm  (imm),
        .res  (nxt_res),
        .bad  (nxt_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= nxt_res;
                illegal <= nxt_bad;
            end
        end
    end

endmodule

// File: rtl/pfalu_checker.sv
module pfalu_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [7:0]  opcode,
    input logic [63:0] dst_val,
    input logic [63:0] src_val,
    input logic        out_valid,
    input logic [63:0] result,
    input logic        illegal
);

    // R13: an accepted instruction yields a result next cycle
    a_r13_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R13: no result without an instruction
    a_r13_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3: narrow non-END results have a clear upper half
    a_r3_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode[2:0] == 3'b100 && opcode[7:4] != 4'hd)
        |=> (illegal || result[63:32] == 32'h0));

    // R12: reserved operation nibbles are refused and leave the destination
    a_r12_reserved_hold: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode[7:4] >= 4'he)
        |=> (illegal && result == $past(dst_val)));

    // R1: foreign class codes are refused
    a_r1_bad_class: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode[2:0] != 3'b100 && opcode[2:0] != 3'b111)
        |=> (illegal && result == $past(dst_val)));

    // R10: wide negate of the destination
    a_r10_neg_wide: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 8'h87)
        |=> (!illegal && result == 64'(64'd0 - $past(dst_val))));

    // R5: wide register move copies the source
    a_r5_mov_wide: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 8'hbf)
        |=> (!illegal && result == $past(src_val)));

endmodule

bind pfalu_top pfalu_checker u_pfalu_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .dst_val   (dst_val),
    .src_val   (src_val),
    .out_valid (out_valid),
    .result    (result),
    .illegal   (illegal)
);

// File: tb/pfalu_top_bench.sv
`timescale 1ns/1ps
module pfalu_top_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  opcode;
    logic [63:0] dst_val;
    logic [63:0] src_val;
    logic [31:0] imm;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal;

    always #2 clk = ~clk;

    pfalu_top u_pfalu_top (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .opcode    (opcode),
        .dst_val   (dst_val),
        .src_val   (src_val),
        .imm       (imm),
        .out_valid (out_valid),
        .result    (result),
        .illegal   (illegal)
    );

    logic [63:0] q_res[$];
    logic        q_ill[$];
    string       q_tag[$];
    int          n_checks = 0;
    int          n_fail   = 0;

    function automatic logic [7:0] mk(input logic [3:0] op, input logic reg_src,
                                      input logic wide);
        return {op, reg_src, wide ? 3'b111 : 3'b100};
    endfunction

    // Reference model written from the requirements
    function automatic void model(input logic [7:0] opc, input logic [63:0] d,
                                  input logic [63:0] s, input logic [31:0] im,
                                  output logic [63:0] r, output logic il);
        logic [63:0] y;
        logic [31:0] x32, y32, z32;
        logic        wide;
        int          nb;
        r  = d;
        il = 1'b0;
        if (opc[2:0] != 3'd4 && opc[2:0] != 3'd7) begin il = 1'b1; return; end
        if (opc[7:4] >= 4'he) begin il = 1'b1; return; end
        wide = (opc[2:0] == 3'd7);
        y    = opc[3] ? s : {{32{im[31]}}, im};
        x32  = d[31:0];
        y32  = y[31:0];
        if (opc[7:4] == 4'hd) begin
            if (im == 32'd16) nb = 2;
            else if (im == 32'd32) nb = 4;
            else if (im == 32'd64) nb = 8;
            else begin il = 1'b1; return; end
            r = 64'd0;
            for (int k = 0; k < nb; k++) begin
                if (opc[3]) r[8*k +: 8] = d[8*(nb-1-k) +: 8];
                else        r[8*k +: 8] = d[8*k +: 8];
            end
            return;
        end
        z32 = 32'd0;
        case (opc[7:4])
            4'h0: begin r = d + y;      z32 = x32 + y32; end
            4'h1: begin r = d - y;      z32 = x32 - y32; end
            4'h2: begin r = d * y;      z32 = x32 * y32; end
            4'h3: begin r = (y == 0) ? 64'd0 : d / y;
                        z32 = (y32 == 0) ? 32'd0 : x32 / y32; end
            4'h4: begin r = d | y;      z32 = x32 | y32; end
            4'h5: begin r = d & y;      z32 = x32 & y32; end
            4'h6: begin r = d << y[5:0]; z32 = x32 << y32[4:0]; end
            4'h7: begin r = d >> y[5:0]; z32 = x32 >> y32[4:0]; end
            4'h8: begin r = ~d + 64'd1;  z32 = ~x32 + 32'd1; end
            4'h9: begin r = (y == 0) ? d : d % y;
                        z32 = (y32 == 0) ? x32 : x32 % y32; end
            4'ha: begin r = d ^ y;      z32 = x32 ^ y32; end
            4'hb: begin r = y;          z32 = y32; end
            default: begin
                r   = $unsigned($signed(d) >>> y[5:0]);
                z32 = $unsigned($signed(x32) >>> y32[4:0]);
            end
        endcase
        if (!wide) r = {32'd0, z32};
    endfunction

    task automatic drive(input logic [7:0] opc, input logic [63:0] d,
                         input logic [63:0] s, input logic [31:0] im,
                         input string tag);
        logic [63:0] er;
        logic        ei;
        model(opc, d, s, im, er, ei);
        q_res.push_back(er);
        q_ill.push_back(ei);
        q_tag.push_back(tag);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        opcode   = opc;
        dst_val  = d;
        src_val  = s;
        imm      = im;
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        opcode   = 8'h00;
        dst_val  = 64'h0;
        src_val  = 64'h0;
        imm      = 32'h0;
    endtask

    // Monitor: compare every produced result against the queue head
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            n_checks++;
            if (q_res.size() == 0) begin
                n_fail++;
                $display("FAIL R13: unexpected output result=%h illegal=%b expected none",
                         result, illegal);
            end else begin
                logic [63:0] er;
                logic        ei;
                string       tg;
                er = q_res.pop_front();
                ei = q_ill.pop_front();
                tg = q_tag.pop_front();
                if (result !== er || illegal !== ei) begin
                    n_fail++;
                    $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
                             tg, result, illegal, er, ei);
                end
            end
        end
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    localparam logic [63:0] PAT = 64'h1122_3344_5566_7788;

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        opcode   = 8'h0;
        dst_val  = 64'h0;
        src_val  = 64'h0;
        imm      = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13: reset state
        n_checks++;
        if (out_valid !== 1'b0 || result !== 64'h0 || illegal !== 1'b0) begin
            n_fail++;
            $display("FAIL R13: reset out_valid=%b result=%h illegal=%b expected 0/0/0",
                     out_valid, result, illegal);
        end
        rst = 1'b0;

        // R1 class selection and foreign classes
        drive(mk(4'h0, 1, 1), 64'h0000_0001_ffff_ffff, 64'h1, 32'h0, "R1");
        drive(mk(4'h0, 1, 0), 64'h0000_0001_ffff_ffff, 64'h1, 32'h0, "R1");
        drive(8'h0d, 64'hdead_beef_0000_0001, 64'h1, 32'h0, "R1");
        drive(8'h05, 64'h0123_4567_89ab_cdef, 64'h1, 32'h0, "R1");
        // R2 operand select and immediate sign extension
        drive(mk(4'h1, 1, 1), 64'd100, 64'd30, 32'd7, "R2");
        drive(mk(4'h1, 0, 1), 64'd100, 64'd30, 32'd7, "R2");
        drive(mk(4'hb, 0, 1), 64'h0, 64'h0, 32'hffff_fff0, "R2");
        drive(mk(4'hb, 0, 0), 64'h0, 64'h0, 32'hffff_fff0, "R2");
        drive(mk(4'h0, 0, 1), 64'h100, 64'h0, 32'hffff_fff0, "R2");
        // R3 narrow truncation and zero extension
        drive(mk(4'h0, 1, 0), 64'h1234_5678_ffff_ffff, 64'hffff_0000_0000_0002, 32'h0, "R3");
        drive(mk(4'h0, 0, 0), 64'h0000_0000_0000_0005, 64'h0, 32'hffff_fff0, "R3");
        drive(mk(4'h7, 0, 0), 64'hffff_ffff_8000_0000, 64'h0, 32'd4, "R3");
        // R4 add/sub/mul wrap
        drive(mk(4'h0, 1, 1), 64'hffff_ffff_ffff_ffff, 64'h1, 32'h0, "R4");
        drive(mk(4'h1, 1, 0), 64'h0, 64'h1, 32'h0, "R4");
        drive(mk(4'h2, 1, 1), 64'h1_0000_0001, 64'h1_0000_0003, 32'h0, "R4");
        drive(mk(4'h2, 1, 0), 64'h1_0001_0000, 64'h0001_0000, 32'h0, "R4");
        // R5 logic and move
        drive(mk(4'h4, 1, 1), 64'hf0f0_0000_0000_00f0, 64'h0f00_0000_0000_000f, 32'h0, "R5");
        drive(mk(4'h5, 0, 0), 64'hffff_ffff_1234_5678, 64'h0, 32'h0000_ff00, "R5");
        drive(mk(4'ha, 1, 1), 64'haaaa_5555_aaaa_5555, 64'hffff_ffff_0000_0000, 32'h0, "R5");
        drive(mk(4'hb, 1, 1), 64'h1, 64'hcafe_f00d_1234_5678, 32'h0, "R5");
        // R6 shift masking
        drive(mk(4'h6, 0, 1), 64'h8000_0000_0000_0003, 64'h0, 32'd65, "R6");
        drive(mk(4'h6, 0, 0), 64'h0000_0000_8000_0003, 64'h0, 32'd33, "R6");
        drive(mk(4'h7, 1, 1), 64'h8000_0000_0000_0000, 64'd63, 32'h0, "R6");
        // R7 arithmetic shift
        drive(mk(4'hc, 0, 1), 64'h8000_0000_0000_0000, 64'h0, 32'd4, "R7");
        drive(mk(4'hc, 0, 0), 64'h0000_0000_8000_0000, 64'h0, 32'd4, "R7");
        drive(mk(4'hc, 1, 0), 64'h0000_0000_4000_0000, 64'd36, 32'h0, "R7");
        // R8 division
        drive(mk(4'h3, 1, 1), 64'hffff_ffff_ffff_ffff, 64'd2, 32'h0, "R8");
        drive(mk(4'h3, 1, 1), 64'd1234, 64'd0, 32'h0, "R8");
        drive(mk(4'h3, 1, 0), 64'h1_0000_0010, 64'h7_0000_0004, 32'h0, "R8");
        drive(mk(4'h3, 0, 0), 64'd77, 64'd0, 32'd0, "R8");
        // R9 remainder
        drive(mk(4'h9, 1, 1), 64'd100, 64'd7, 32'h0, "R9");
        drive(mk(4'h9, 1, 1), 64'habcd_0000_1234_5678, 64'd0, 32'h0, "R9");
        drive(mk(4'h9, 1, 0), 64'habcd_0000_1234_5678, 64'h5_0000_0000, 32'h0, "R9");
        // R10 negate ignores operand
        drive(mk(4'h8, 1, 1), 64'd1, 64'h5555, 32'h1234, "R10");
        drive(mk(4'h8, 0, 1), 64'd1, 64'h0, 32'hffff_ffff, "R10");
        drive(mk(4'h8, 1, 0), 64'hffff_0000_0000_0001, 64'h7, 32'h0, "R10");
        // R11 byte order
        drive(mk(4'hd, 0, 0), PAT, 64'h0, 32'd16, "R11");
        drive(mk(4'hd, 1, 0), PAT, 64'h0, 32'd16, "R11");
        drive(mk(4'hd, 1, 0), PAT, 64'h0, 32'd32, "R11");
        drive(mk(4'hd, 1, 0), PAT, 64'h0, 32'd64, "R11");
        drive(mk(4'hd, 0, 0), PAT, 64'h0, 32'd64, "R11");
        drive(mk(4'hd, 0, 1), PAT, 64'h0, 32'd32, "R11");
        drive(mk(4'hd, 1, 0), PAT, 64'h0, 32'd8, "R11");
        // R12 reserved operations
        drive(mk(4'he, 1, 1), 64'h0bad_0bad_0bad_0bad, 64'h1, 32'h0, "R12");
        drive(mk(4'hf, 0, 0), 64'hffff_ffff_0000_1111, 64'h1, 32'h1, "R12");
        idle();
        // R13: a gap produces no output
        @(negedge clk);
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R13: out_valid=%b during gap expected 0", out_valid);
        end
        drive(mk(4'h0, 1, 1), 64'd40, 64'd2, 32'h0, "R13");
        idle();
        repeat (4) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (q_res.size() != 0) begin
            n_fail++;
            $display("FAIL R13: %0d results missing expected 0", q_res.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule